// File: doc/BRIEF.md
# Memory-Stall Slack Estimator with Proportional Frequency Step

This block turns three event counts gathered over one sampling window into an estimate of how much of that window the processor spent stalled on memory with no useful work to cover the wait. The three counts are memory bus transactions, retired micro-operations, and retired integer plus floating-point instructions. It also turns that estimate into a proportional number of frequency-reduction steps. Two calibration weights scale the memory term and the overlap term. A gain converts slack into steps, and a limit gives the deepest step allowed. All four are programmable inputs.

When the window-done strobe arrives, the block takes the counts and settings and forms the weighted difference `k_mem*mem - k_ovl*comp`, with negative results clamped to zero. It divides that difference by the micro-operation count in a bit-serial divider. It then registers the slack (an unsigned value with 8 fractional bits) and the step count together with a one-cycle valid pulse. Both results then stay fixed until the next window finishes. A power manager reads the step count and applies it. The counters and the clock and voltage control are outside this block.

Top module: `slk_est`

## Requirements
- R1: After reset, `slack_o`, `step_o`, `valid_o` and `busy_o` are all 0.
- R2: Weights are unsigned with 8 fractional bits (0x0100 = 1.0). With a zero overlap term, slack = floor(k_mem*mem / uop), read as a value with 8 fractional bits.
- R3: The overlap term is subtracted before dividing: slack = floor((k_mem*mem - k_ovl*comp) / uop).
- R4: When k_ovl*comp is greater than or equal to k_mem*mem, slack and step are both 0.
- R5: A window with zero retired micro-operations gives slack 0 and step 0.
- R6: A quotient above 2^SLK_W-1 saturates slack at 2^SLK_W-1 (0xFFFF by default).
- R7: step = floor(slack * gain / 256), where gain is an unsigned integer.
- R8: step never exceeds the limit input captured with the window. Larger values are clamped to that limit.
- R9: A strobe accepted at clock edge E gives new outputs and a single-cycle `valid_o` at edge E+33 (PROD_W+1 with default widths). `busy_o` is 1 from E until that edge.
- R10: Outputs hold their values between results. A strobe that arrives while `busy_o` is 1 is ignored, and the result in progress is unchanged.
- R11: Counts, weights, gain and limit are sampled only on the accepted strobe. Changing them afterwards does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_done_i | input | 1 | Window-complete strobe |
| mem_txn_i | input | CNT_W | Memory bus transactions in the window |
| uop_ret_i | input | CNT_W | Retired micro-operations in the window |
| comp_ret_i | input | CNT_W | Retired integer plus floating-point instructions |
| k_mem_i | input | K_W | Memory-term weight, 8 fractional bits |
| k_ovl_i | input | K_W | Overlap-term weight, 8 fractional bits |
| gain_i | input | GAIN_W | Steps per unit of slack |
| lim_step_i | input | STEP_W | Deepest allowed reduction step |
| slack_o | output | SLK_W | Relative slack, 8 fractional bits |
| step_o | output | STEP_W | Frequency reduction step |
| valid_o | output | 1 | One-cycle pulse when a new result is registered |
| busy_o | output | 1 | Calculation in progress |

## Verification
The bench runs windows with several kinds of input. A pure memory term with no overlap isolates the weighting and the division. A mixed term shows that subtraction happens before division and not after. An overlap larger than the memory term, and a window with zero micro-operations, must both end at zero by different paths. An extreme window drives saturation and step clamping. Repeating one window under two limits separates the proportional step from the clamp. Two further cases check timing and sampling. A second strobe during a calculation checks that it is ignored. Scrambling the inputs right after a strobe checks that values are taken only at the strobe.

// File: rtl/slk_pkg.sv
package slk_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } slk_state_e;
endpackage

// File: rtl/slk_term_diff.sv
module slk_term_diff #(
  parameter int CNT_W = 16,
  parameter int K_W   = 16,
  localparam int PROD_W = CNT_W + K_W
) (
  input  logic [CNT_W-1:0]  mem_i,
  input  logic [CNT_W-1:0]  comp_i,
  input  logic [K_W-1:0]    k_mem_i,
  input  logic [K_W-1:0]    k_ovl_i,
  output logic [PROD_W-1:0] diff_o,
  output logic              neg_o
);
  // Weighted memory time minus weighted overlap, clamped at zero
  function automatic logic [PROD_W-1:0] weigh(input logic [CNT_W-1:0] cnt,
                                              input logic [K_W-1:0] k);
    return PROD_W'(cnt) * PROD_W'(k);
  endfunction

  logic [PROD_W-1:0] mem_term;
  logic [PROD_W-1:0] ovl_term;

  always_comb begin
    mem_term = weigh(mem_i, k_mem_i);
    ovl_term = weigh(comp_i, k_ovl_i);
    neg_o    = (ovl_term >= mem_term);
    diff_o   = neg_o ? '0 : (mem_term - ovl_term);
  end
endmodule

// File: rtl/slk_seq_div.sv
module slk_seq_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16,
  localparam int CW = $clog2(NUM_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    cnt_q;
  logic             done_q;

  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   trial_sub;
  logic             fits;

  // One restoring-division bit per clock
  always_comb begin
    trial     = {rem_q, quo_q[NUM_W-1]};
    fits      = (trial >= {1'b0, den_q});
    trial_sub = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= num_i;
      den_q  <= den_i;
      cnt_q  <= CW'(NUM_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= fits ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_q  <= {quo_q[NUM_W-2:0], fits};
      cnt_q  <= cnt_q - CW'(1);
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/slk_step_map.sv
module slk_step_map #(
  parameter int QUO_W  = 32,
  parameter int SLK_W  = 16,
  parameter int GAIN_W = 8,
  parameter int STEP_W = 4,
  parameter int FRAC   = 8,
  localparam int MUL_W = SLK_W + GAIN_W
) (
  input  logic [QUO_W-1:0]  quo_i,
  input  logic              zero_den_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [STEP_W-1:0] lim_i,
  output logic [SLK_W-1:0]  slack_o,
  output logic [STEP_W-1:0] step_o
);
  logic [SLK_W-1:0] sat_q;

  // Saturate the quotient into the slack width
  generate
    if (QUO_W > SLK_W) begin : g_sat
      assign sat_q = (|quo_i[QUO_W-1:SLK_W]) ? {SLK_W{1'b1}} : quo_i[SLK_W-1:0];
    end else begin : g_pass
      assign sat_q = SLK_W'(quo_i);
    end
  endgenerate

  function automatic logic [STEP_W-1:0] to_step(input logic [SLK_W-1:0] s,
                                                input logic [GAIN_W-1:0] g,
                                                input logic [STEP_W-1:0] lim);
    logic [MUL_W-1:0] raw;
    raw = (MUL_W'(s) * MUL_W'(g)) >> FRAC;
    return (raw > MUL_W'(lim)) ? lim : raw[STEP_W-1:0];
  endfunction

  always_comb begin
    slack_o = zero_den_i ? '0 : sat_q;
    step_o  = to_step(slack_o, gain_i, lim_i);
  end
endmodule

// File: rtl/slk_est.sv
module slk_est #(
  parameter int CNT_W  = 16,
  parameter int K_W    = 16,
  parameter int SLK_W  = 16,
  parameter int GAIN_W = 8,
  parameter int STEP_W = 4,
  parameter int FRAC   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_done_i,
  input  logic [CNT_W-1:0]  mem_txn_i,
  input  logic [CNT_W-1:0]  uop_ret_i,
  input  logic [CNT_W-1:0]  comp_ret_i,
  input  logic [K_W-1:0]    k_mem_i,
  input  logic [K_W-1:0]    k_ovl_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [STEP_W-1:0] lim_step_i,
  output logic [SLK_W-1:0]  slack_o,
  output logic [STEP_W-1:0] step_o,
  output logic              valid_o,
  output logic              busy_o
);
  import slk_pkg::*;
  localparam int PROD_W = CNT_W + K_W;

  slk_state_e        state_q;
  logic              accept;
  logic [PROD_W-1:0] diff_w;
  logic              neg_w;
  logic              div_done;
  logic [PROD_W-1:0] quo_w;
  logic              zero_den_q;
  logic              neg_q;
  logic [GAIN_W-1:0] gain_q;
  logic [STEP_W-1:0] lim_q;
  logic [SLK_W-1:0]  slack_w;
  logic [STEP_W-1:0] step_w;
  logic [SLK_W-1:0]  slack_q;
  logic [STEP_W-1:0] step_q;
  logic              valid_q;

  assign accept = win_done_i && (state_q == ST_IDLE);

  slk_term_diff #(.CNT_W(CNT_W), .K_W(K_W)) u_diff (
    .mem_i   (mem_txn_i),
    .comp_i  (comp_ret_i),
    .k_mem_i (k_mem_i),
    .k_ovl_i (k_ovl_i),
    .diff_o  (diff_w),
    .neg_o   (neg_w)
  );

  slk_seq_div #(.NUM_W(PROD_W), .DEN_W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .num_i   (diff_w),
    .den_i   (uop_ret_i),
    .done_o  (div_done),
    .quo_o   (quo_w)
  );

  slk_step_map #(
    .QUO_W(PROD_W), .SLK_W(SLK_W), .GAIN_W(GAIN_W),
    .STEP_W(STEP_W), .FRAC(FRAC)
  ) u_map (
    .quo_i      (quo_w),
    .zero_den_i (zero_den_q),
    .gain_i     (gain_q),
    .lim_i      (lim_q),
    .slack_o    (slack_w),
    .step_o     (step_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      zero_den_q <= 1'b0;
      neg_q      <= 1'b0;
      gain_q     <= '0;
      lim_q      <= '0;
    end else if (accept) begin
      state_q    <= ST_RUN;
      zero_den_q <= (uop_ret_i == '0);
      neg_q      <= neg_w;
      gain_q     <= gain_i;
      lim_q      <= lim_step_i;
    end else if (div_done) begin
      state_q    <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slack_q <= '0;
      step_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= div_done && (state_q == ST_RUN);
      if (div_done && (state_q == ST_RUN)) begin
        slack_q <= slack_w;
        step_q  <= step_w;
      end
    end
  end

  assign slack_o = slack_q;
  assign step_o  = step_q;
  assign valid_o = valid_q;
  assign busy_o  = (state_q == ST_RUN);
endmodule

// File: rtl/slk_est_chk.sv
module slk_est_chk #(
  parameter int SLK_W  = 16,
  parameter int STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              busy_i,
  input logic [SLK_W-1:0]  slack_i,
  input logic [STEP_W-1:0] step_i,
  input logic [STEP_W-1:0] lim_i,
  input logic              zero_den_i,
  input logic              neg_i,
  input logic              div_done_i
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> !valid_i); // R9
  AST_VALID_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |-> $past(busy_i)); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) div_done_i |-> busy_i); // R9
  AST_HOLD_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |-> ($stable(slack_i) && $stable(step_i))); // R10
  AST_STEP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |-> (step_i <= lim_i)); // R8
  AST_ZERO_UOP: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && zero_den_i) |-> (slack_i == '0 && step_i == '0)); // R5
  AST_NEG_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && neg_i) |-> (slack_i == '0)); // R4
endmodule

bind slk_est slk_est_chk #(.SLK_W(SLK_W), .STEP_W(STEP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_o),
  .busy_i     (busy_o),
  .slack_i    (slack_o),
  .step_i     (step_o),
  .lim_i      (lim_q),
  .zero_den_i (zero_den_q),
  .neg_i      (neg_q),
  .div_done_i (div_done)
);

// File: tb/slk_est_bench.sv
module slk_est_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_done = 1'b0;
  logic [15:0] mem_txn = '0, uop_ret = '0, comp_ret = '0, k_mem = '0, k_ovl = '0;
  logic [7:0]  gain = '0;
  logic [3:0]  lim = '0;
  logic [15:0] slack;
  logic [3:0]  step;
  logic        valid, busy;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  slk_est u_slk_est (
    .clk_i(clk), .rst_ni(rst_n), .win_done_i(win_done),
    .mem_txn_i(mem_txn), .uop_ret_i(uop_ret), .comp_ret_i(comp_ret),
    .k_mem_i(k_mem), .k_ovl_i(k_ovl), .gain_i(gain), .lim_step_i(lim),
    .slack_o(slack), .step_o(step), .valid_o(valid), .busy_o(busy)
  );

  function automatic longint ref_slack(longint m, longint u, longint c, longint k1, longint k2);
    longint d;
    if (u == 0) return 0;
    d = k1 * m - k2 * c;
    if (d <= 0) return 0;
    d = d / u;
    return (d > 65535) ? 65535 : d;
  endfunction

  function automatic longint ref_step(longint s, longint g, longint l);
    longint t;
    t = (s * g) / 256;
    return (t > l) ? l : t;
  endfunction

  // Behavioural reference: a countdown and the pending result
  int     mdl_cnt = 0;
  longint mdl_pend_s = 0, mdl_pend_t = 0;
  longint exp_s = 0, exp_t = 0;
  bit     exp_v = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_cnt = 0; exp_s = 0; exp_t = 0; exp_v = 1'b0;
    end else if (mdl_cnt > 0) begin
      mdl_cnt--;
      exp_v = (mdl_cnt == 0);
      if (mdl_cnt == 0) begin
        exp_s = mdl_pend_s; exp_t = mdl_pend_t;
      end
    end else begin
      exp_v = 1'b0;
      if (win_done) begin
        mdl_pend_s = ref_slack(mem_txn, uop_ret, comp_ret, k_mem, k_ovl);
        mdl_pend_t = ref_step(mdl_pend_s, gain, lim);
        mdl_cnt = 33;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Every-clock comparison against the model (R9 timing, R10 hold)
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check(valid == exp_v, "R9 valid", valid, exp_v);
      check(slack == exp_s[15:0], "R10 slack", slack, exp_s);
      check(step == exp_t[3:0], "R10 step", step, exp_t);
      check(busy == (mdl_cnt > 0), "R9 busy", busy, mdl_cnt > 0);
    end
  end

  task automatic run_win(input string req, input logic [15:0] m, u, c, k1, k2,
                         input logic [7:0] g, input logic [3:0] l,
                         input longint es, input longint et);
    @(negedge clk);
    mem_txn = m; uop_ret = u; comp_ret = c; k_mem = k1; k_ovl = k2; gain = g; lim = l;
    win_done = 1'b1;
    @(negedge clk);
    win_done = 1'b0;
    // R11: scramble inputs after the strobe
    mem_txn = 16'h1234; uop_ret = 16'h0003; comp_ret = 16'h0000; k_mem = 16'hFFFF;
    k_ovl = 16'h0000; gain = 8'hFF; lim = 4'hF;
    repeat (32) @(negedge clk);
    check(valid == 1'b0, {req, " R9 early"}, valid, 0);
    @(negedge clk);
    check(valid == 1'b1, {req, " R9 on time"}, valid, 1);
    check(slack == es[15:0], {req, " slack"}, slack, es);
    check(step == et[3:0], {req, " step"}, step, et);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(slack == 0 && step == 0 && valid == 0 && busy == 0, "R1 reset", {slack, step, valid, busy}, 0);
    rst_n = 1'b1;
    // R2: memory term only; 2.0*100*256/1000 -> 51, step 51*64/256 = 12
    run_win("R2", 16'd100, 16'd1000, 16'd0, 16'h0200, 16'h0000, 8'h40, 4'd15, 51, 12);
    // R3, R7: (51200-38400)/1000 = 12, step 3; R11 via scrambling in task
    run_win("R3 R7 R11", 16'd100, 16'd1000, 16'd300, 16'h0200, 16'h0080, 8'h40, 4'd15, 12, 3);
    // R4: overlap exceeds memory term
    run_win("R4", 16'd100, 16'd1000, 16'd900, 16'h0200, 16'h0100, 8'hFF, 4'd15, 0, 0);
    // R4: exactly equal terms
    run_win("R4 equal", 16'd100, 16'd500, 16'd200, 16'h0200, 16'h0100, 8'hFF, 4'd15, 0, 0);
    // R5: zero micro-operations
    run_win("R5", 16'd500, 16'd0, 16'd0, 16'h0400, 16'h0000, 8'hFF, 4'd15, 0, 0);
    // R6, R8: saturation and clamp
    run_win("R6 R8", 16'hFFFF, 16'd1, 16'd0, 16'hFFFF, 16'h0000, 8'h40, 4'd15, 65535, 15);
    // R7: 0.5*256 memory fraction: 1.0*400/800 -> 128, gain 10 -> 5
    run_win("R7", 16'd400, 16'd800, 16'd0, 16'h0100, 16'h0000, 8'd10, 4'd15, 128, 5);
    // R8: same window with lower limit
    run_win("R8", 16'd400, 16'd800, 16'd0, 16'h0100, 16'h0000, 8'd10, 4'd3, 128, 3);
    // R10: strobe while busy is ignored
    @(negedge clk);
    mem_txn = 16'd300; uop_ret = 16'd600; comp_ret = 16'd0; k_mem = 16'h0100; k_ovl = 16'h0000;
    gain = 8'd4; lim = 4'd15; win_done = 1'b1;
    @(negedge clk);
    mem_txn = 16'd600; uop_ret = 16'd1; k_mem = 16'h0800; gain = 8'hFF;
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R10 busy during run", busy, 1);
    win_done = 1'b0;
    repeat (28) @(negedge clk);
    check(valid == 1'b1 && slack == 16'd128 && step == 4'd2, "R10 ignored strobe", slack, 128);
    repeat (10) @(negedge clk);
    check(slack == 16'd128 && step == 4'd2, "R10 hold", slack, 128);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule